// File: doc/BRIEF.md
# Iterative Request-Grant-Accept Crossbar Matcher

This block schedules the crossbar of an N-by-N input-queued switch that keeps a separate queue for every output at each input. Once per time slot the surrounding logic presents a request matrix: input i raises the bit for output j when it holds cells for output j. On a start pulse the matcher latches that matrix and runs request-grant-accept iterations, one per clock cycle. In each iteration every output that is still free grants one of the free inputs that request it. Every free input that receives grants accepts one of them, and the accepted pairs are added to the match.

Grant and accept choices are round-robin. Each output and each input keeps a pointer, and the search starts at that pointer. Pointers move only for pairs accepted in the first iteration of a slot. The run stops after an iteration that adds no pair, or when the iteration limit is reached. A one-cycle done pulse then marks the match as final. The match stays on the outputs until the next start, and the crossbar is configured from it for the following slot.

Top module: `rga_matcher`

## Requirements
- R1: A start pulse while idle latches `req` and raises `busy` on the next edge. A start pulse while busy is ignored, so the result of the current run depends only on the matrix latched at its start.
- R2: In the final match no output index is used by more than one input, and each input holds at most one output.
- R3: An input is matched to output j only if request bit i*N+j of the latched matrix was set. An all-zero matrix gives no valid match.
- R4: When ITER >= N, the final match is maximal: no unmatched input has a request to an unmatched output.
- R5: Grants and accepts pick the first candidate at or after the port's pointer, wrapping modulo N. All pointers reset to 0.
- R6: Only pairs accepted in the first iteration of a run move pointers: output j's pointer becomes i+1 mod N and input i's pointer becomes j+1 mod N.
- R7: Each iteration takes one clock cycle. The run ends after the iteration that adds no pair or after iteration ITER, whichever comes first. `done` is high for exactly the one cycle after the final iteration's edge, so the latency from the start edge equals the number of iterations run.
- R8: After reset `busy`, `done` and `match_vld` are 0.
- R9: Input i's match is reported as `match_vld[i]` with the output index in `match_idx[i*IW +: IW]`. These outputs hold their value from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a match for the presented matrix |
| req | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: match is final |
| match_vld | output | N | Input i is matched |
| match_idx | output | N*IW | Output index per input |

## Verification
Two actions can fall in the same cycle. An iteration can add new pairs while its first-iteration acceptances also move the round-robin pointers. In addition, a new start can arrive while a run is still iterating. The first case is provoked with three back-to-back all-ones matrices from reset, where the pointer rotation must produce the pairings and latencies computed by hand. The second case is provoked by a start with a full matrix one cycle into a single-request run, and the result must show only the original pair. Every 3x3 matrix is then swept, and the bench checks that each match is conflict-free, uses only requested pairs and is maximal.

// File: rtl/rga_pkg.sv
package rga_pkg;
    // Increment modulo n, used for round-robin pointer updates
    function automatic int unsigned wrap_inc(int unsigned x, int unsigned n);
        return (x + 1 >= n) ? 0 : x + 1;
    endfunction
endpackage

// File: rtl/rga_rr_pick.sv
module rga_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // First set candidate at or after ptr, wrapping modulo N
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int unsigned p;
            p = int'(ptr) + k;
            if (p >= N) p = p - N;
            if (!hit && cand[p]) begin
                hit = 1'b1;
                idx = IW'(p);
            end
        end
    end
endmodule

// File: rtl/rga_matcher.sv
module rga_matcher #(
    parameter int N    = 4,
    parameter int ITER = 4,
    localparam int IW  = (N > 1) ? $clog2(N) : 1,
    localparam int CW  = $clog2(ITER + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*N-1:0]  req,
    output logic            busy,
    output logic            done,
    output logic [N-1:0]    match_vld,
    output logic [N*IW-1:0] match_idx
);
    import rga_pkg::*;

    typedef struct packed {
        logic                   busy;
        logic                   done;
        logic [CW-1:0]          iter;
        logic [N-1:0][N-1:0]    req;
        logic [N-1:0]           imat;
        logic [N-1:0]           omat;
        logic [N-1:0][IW-1:0]   midx;
        logic [N-1:0][IW-1:0]   gptr;
        logic [N-1:0][IW-1:0]   aptr;
    } state_t;

    state_t st_q, st_d;

    logic [N-1:0]  gcand [N];
    logic [N-1:0]  ghit;
    logic [IW-1:0] gidx  [N];
    logic [N-1:0]  acand [N];
    logic [N-1:0]  ahit;
    logic [IW-1:0] aidx  [N];

    // Grant stage: each free output picks one free requesting input
    for (genvar j = 0; j < N; j++) begin : g_grant
        always_comb begin
            for (int i = 0; i < N; i++)
                gcand[j][i] = st_q.req[i][j] & ~st_q.imat[i] & ~st_q.omat[j];
        end
        rga_rr_pick #(.N(N), .IW(IW)) i_gpick (
            .cand(gcand[j]), .ptr(st_q.gptr[j]), .hit(ghit[j]), .idx(gidx[j])
        );
    end

    // Accept stage: each free input picks one of the grants it received
    for (genvar i = 0; i < N; i++) begin : g_accept
        always_comb begin
            for (int j = 0; j < N; j++)
                acand[i][j] = ghit[j] && (gidx[j] == IW'(i)) && !st_q.imat[i];
        end
        rga_rr_pick #(.N(N), .IW(IW)) i_apick (
            .cand(acand[i]), .ptr(st_q.aptr[i]), .hit(ahit[i]), .idx(aidx[i])
        );
    end

    always_comb begin
        logic added;
        st_d      = st_q;
        st_d.done = 1'b0;
        added     = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.req  = req;
                st_d.imat = '0;
                st_d.omat = '0;
                st_d.midx = '0;
                st_d.iter = '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ahit[i]) begin
                    added             = 1'b1;
                    st_d.imat[i]      = 1'b1;
                    st_d.omat[aidx[i]] = 1'b1;
                    st_d.midx[i]      = aidx[i];
                    if (st_q.iter == '0) begin
                        st_d.aptr[i]       = IW'(wrap_inc(int'(aidx[i]), N));
                        st_d.gptr[aidx[i]] = IW'(wrap_inc(i, N));
                    end
                end
            end
            st_d.iter = st_q.iter + 1'b1;
            if (!added || (st_q.iter + 1'b1 == CW'(ITER))) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign match_vld = st_q.imat;
    assign match_idx = st_q.midx;

    // ---------------- assertions ----------------
    assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.req));

    for (genvar a = 0; a < N; a++) begin : g_chk
        for (genvar b = a + 1; b < N; b++) begin : g_pair
            assert_unique_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.done && st_q.imat[a] && st_q.imat[b]) |-> (st_q.midx[a] != st_q.midx[b]));
        end
        assert_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.done && st_q.imat[a]) |-> st_q.req[a][st_q.midx[a]]);
        if (ITER >= N) begin : g_max
            assert_maximal_R4: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.done |-> (st_q.imat[a] || ((st_q.req[a] & ~st_q.omat) == '0)));
        end
    end

    assert_ptr_first_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.busy && st_q.iter == '0) |=> ($stable(st_q.gptr) && $stable(st_q.aptr)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start) |=> ($stable(st_q.imat) && $stable(st_q.midx)));
endmodule

// File: tb/test_rga_matcher.sv
module test_rga_matcher;
    localparam int N    = 3;
    localparam int ITER = 3;
    localparam int IW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*N-1:0]  req = '0;
    logic            busy, done;
    logic [N-1:0]    match_vld;
    logic [N*IW-1:0] match_idx;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rga_matcher #(.N(N), .ITER(ITER)) i_rga_matcher (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req),
        .busy(busy), .done(done), .match_vld(match_vld), .match_idx(match_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int midx(int i);
        return int'(match_idx[i*IW +: IW]);
    endfunction

    // Pack expected matching as 3 base-4 digits (3 = unmatched)
    function automatic int code_act();
        int c = 0;
        for (int i = 0; i < N; i++) c = c * 4 + (match_vld[i] ? midx(i) : 3);
        return c;
    endfunction

    // Run one slot; optionally poke a second start while busy
    task automatic run(input logic [N*N-1:0] r, input bit poke, output int lat);
        @(negedge clk);
        req = r; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            req = '1; start = 1'b1;
        end
        lat = 0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (done || lat > 20) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(busy == 0 && done == 0 && match_vld == 0, "R8 reset", {busy, done, match_vld}, 0);
        rst_n = 1'b1;

        // R5/R6/R7: all-ones rotation from reset pointers
        run('1, 0, lat);
        check(code_act() == ((0*4+1)*4+2), "R5 full#1 match", code_act(), (0*4+1)*4+2);
        check(lat == 3, "R7 full#1 latency", lat, 3);
        run('1, 0, lat);
        check(code_act() == ((1*4+0)*4+2), "R6 full#2 match", code_act(), (1*4+0)*4+2);
        check(lat == 3, "R7 full#2 latency", lat, 3);
        run('1, 0, lat);
        check(code_act() == ((2*4+1)*4+0), "R6 full#3 match", code_act(), (2*4+1)*4+0);
        check(lat == 2, "R7 full#3 latency", lat, 2);

        // R3/R7: empty matrix
        run('0, 0, lat);
        check(match_vld == 0, "R3 empty", match_vld, 0);
        check(lat == 1, "R7 empty latency", lat, 1);

        // R1: start while busy ignored (input1 -> output2 only, bit 5)
        run(9'b000100000, 1, lat);
        check(code_act() == ((3*4+2)*4+3), "R1 busy start", code_act(), (3*4+2)*4+3);
        check(lat == 2, "R7 single latency", lat, 2);
        // R9: outputs hold while idle
        repeat (3) @(negedge clk);
        check(code_act() == ((3*4+2)*4+3), "R9 hold", code_act(), (3*4+2)*4+3);

        // Exhaustive sweep: R2, R3, R4
        for (int m = 0; m < (1 << (N*N)); m++) begin
            logic [N*N-1:0] r;
            bit conflict, unreq, gap;
            logic [N-1:0] used;
            r = m[N*N-1:0];
            run(r, 0, lat);
            conflict = 0; unreq = 0; gap = 0; used = '0;
            for (int i = 0; i < N; i++) begin
                if (match_vld[i]) begin
                    if (midx(i) >= N || used[midx(i)]) conflict = 1;
                    else used[midx(i)] = 1'b1;
                    if (midx(i) < N && !r[i*N + midx(i)]) unreq = 1;
                end
            end
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (r[i*N+j] && !match_vld[i] && !used[j]) gap = 1;
            check(!conflict, "R2 conflict-free", m, 0);
            check(!unreq, "R3 requested only", m, 0);
            check(!gap, "R4 maximal", m, 0);
            check(lat >= 1 && lat <= ITER, "R7 latency bound", lat, ITER);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule